// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block drives one byte-wide output channel toward an external device and paces each transfer with a two-wire handshake. The host offers a byte on a valid/ready write stream. Each accepted byte is held on the output pins, and an active-low buffer-full line tells the device that fresh data is waiting. The device takes the byte and answers with a low pulse on its active-low acknowledge line.

The falling edge of acknowledge empties the buffer. When acknowledge returns high, the block can raise an interrupt, if the host has enabled it, to ask for the next byte. A host that does not use the interrupt can poll an 8-bit status word instead. That word reports the buffer-full level, the synchronized acknowledge level and the interrupt level.

Back-pressure rules for the write stream: `wr_ready` is high exactly when the buffer is empty. A byte is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. While the buffer is full, the host must keep its byte and its `wr_valid` until `wr_ready` returns. A byte is never overwritten before the device has acknowledged it. The acknowledge input is asynchronous and passes through a chain of `SYNC_STAGES` flip-flops before it is used.

Top module: `strobe_out_port`

## Requirements
- R1: After reset, `obf_n` = 1, `intr` = 0, `dout` = 0 and `wr_ready` = 1.
- R2: On an accepted write, the byte appears on `dout` and `obf_n` goes low after the same rising edge.
- R3: `wr_ready` equals `obf_n`. A write offered while `obf_n` = 0 is not taken, and `dout` stays unchanged.
- R4: `dout` holds its value in every cycle that has no accepted write.
- R5: A falling edge on `ack_n` sets `obf_n` back to 1. With the default two synchronizer stages, `obf_n` is high three rising edges after `ack_n` goes low.
- R6: `intr` is 1 only when all of these hold: an acknowledge has emptied the buffer since the last accepted write, the synchronized `ack_n` is back at 1, `obf_n` = 1, and `ie` = 1. An accepted write clears `intr` after its edge.
- R7: `ie` = 0 holds `intr` at 0 without losing the pending request. Raising `ie` again makes `intr` 1 at once.
- R8: A falling edge on `ack_n` while `obf_n` is already 1 does not change `dout` or `obf_n`. Once `ack_n` is high again, `intr` has the same level it had before that edge.
- R9: The `status` word has these fields:
  - bit 7 = `obf_n`
  - bit 6 = synchronized `ack_n`
  - bit 3 = `intr`
  - all other bits = 0
- R10: `ack_n` passes through `SYNC_STAGES` flip-flops. With the default setting, `obf_n` is still 0 two rising edges after `ack_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Buffer empty; the offered byte is taken on this edge |
| wr_data | input | DATA_W | Host byte |
| dout | output | DATA_W | Latched byte to the device |
| obf_n | output | 1 | Buffer full, active low |
| ack_n | input | 1 | Device acknowledge, active low, asynchronous |
| ie | input | 1 | Interrupt enable |
| intr | output | 1 | Interrupt request to the host |
| status | output | 8 | Polled status word (bit 7 buffer-full, bit 6 acknowledge, bit 3 interrupt) |

## Verification
The bench compares every check against its own model of the buffer-full flag, the pending request and the latched byte.

A buffer-full flag stuck in the wrong state shows up on the cycle after the next write attempt. In that cycle, `wr_ready`, `obf_n` and status bit 7 all disagree with the model. A lost or spurious pending request shows on `intr` once the acknowledge line is high again, two edges after its rising edge. An acknowledge edge detected at the wrong cycle shows at the two- and three-edge sample points that follow each low pulse.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned STAT_OBF  = 7;
  localparam int unsigned STAT_ACK  = 6;
  localparam int unsigned STAT_INTR = 3;

  function automatic logic [STATUS_W-1:0] pack_status(input logic obf_n_v,
                                                      input logic ack_v,
                                                      input logic intr_v);
    logic [STATUS_W-1:0] s;
    s            = '0;
    s[STAT_OBF]  = obf_n_v;
    s[STAT_ACK]  = ack_v;
    s[STAT_INTR] = intr_v;
    return s;
  endfunction
endpackage

// File: rtl/sop_ack_sync.sv
module sop_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_async,
  output logic ack_lvl,
  output logic ack_fall
);
  // Stages 0..STAGES-1 synchronize the input; stage STAGES holds the previous level.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], ack_n_async};
  end

  assign ack_lvl  = chain[STAGES-1];
  assign ack_fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/sop_data_latch.sv
module sop_data_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/sop_hs_ctrl.sv
module sop_hs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic ack_fall,
  input  logic ack_lvl,
  input  logic ie,
  output logic full,
  output logic intr
);
  // pend: the device has taken the last byte and no new byte has been accepted yet.
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      pend <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      pend <= 1'b0;
    end else if (ack_fall && full) begin
      full <= 1'b0;
      pend <= 1'b1;
    end
  end

  assign intr = pend & ack_lvl & ~full & ie;
endmodule

// File: rtl/strobe_out_port.sv
module strobe_out_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             dout,
  output logic                          obf_n,
  input  logic                          ack_n,
  input  logic                          ie,
  output logic                          intr,
  output logic [sop_pkg::STATUS_W-1:0]  status
);
  logic full, load, ack_lvl, ack_fall;

  assign wr_ready = ~full;
  assign load     = wr_valid & ~full;
  assign obf_n    = ~full;

  sop_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n_async(ack_n),
    .ack_lvl(ack_lvl), .ack_fall(ack_fall)
  );

  sop_data_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .load(load), .din(wr_data), .dout(dout)
  );

  sop_hs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .load(load), .ack_fall(ack_fall), .ack_lvl(ack_lvl),
    .ie(ie), .full(full), .intr(intr)
  );

  assign status = sop_pkg::pack_status(~full, ack_lvl, intr);
endmodule

// File: rtl/strobe_out_port_chk.sv
module strobe_out_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] dout,
  input logic              obf_n,
  input logic              ie,
  input logic              intr,
  input logic [7:0]        status
);
  assert_accept_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (!obf_n && dout == $past(wr_data)));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (!obf_n && status[6]) |=> (!obf_n && !wr_ready));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> $stable(dout));

  assert_intr_gated_R6: assert property (@(posedge clk) disable iff (rst)
    intr |-> (obf_n && ie && status[6]));

  assert_write_clears_intr_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !intr);

  assert_status_intr_R9: assert property (@(posedge clk) disable iff (rst)
    status[3] == intr && status[7] == obf_n);
endmodule

bind strobe_out_port strobe_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .dout(dout), .obf_n(obf_n), .ie(ie), .intr(intr),
  .status(status)
);

// File: tb/test_strobe_out_port.sv
module test_strobe_out_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic ack_n = 1'b1;
  logic ie = 1'b0;
  logic wr_ready, obf_n, intr;
  logic [DW-1:0] dout;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model
  bit m_full = 0;
  bit m_pend = 0;
  bit m_ie = 0;
  logic [DW-1:0] m_dout = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_out_port #(.DATA_W(DW), .SYNC_STAGES(2)) i_strobe_out_port (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .dout(dout), .obf_n(obf_n), .ack_n(ack_n),
    .ie(ie), .intr(intr), .status(status)
  );

  function automatic logic exp_intr(input bit ack_hi);
    return m_pend && ack_hi && !m_full && m_ie;
  endfunction

  function automatic logic [7:0] exp_status(input bit ack_hi);
    logic [7:0] s = '0;
    s[7] = !m_full;
    s[6] = ack_hi;
    s[3] = exp_intr(ack_hi);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit ack_hi);
    chk({req, " obf_n"}, obf_n, !m_full);
    chk({req, " wr_ready R3"}, wr_ready, !m_full);
    chk({req, " dout R4"}, dout, m_dout);
    chk({req, " intr R6"}, intr, exp_intr(ack_hi));
    chk({req, " status R9"}, status, exp_status(ack_hi));
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    if (!m_full) begin
      m_full = 1; m_pend = 0; m_dout = d;
      check_all("R2 write", 1'b1);
    end else begin
      check_all("R3 write while full", 1'b1);
    end
  endtask

  task automatic do_ack();
    bit was_full = m_full;
    bit intr_before = exp_intr(1'b1);
    @(negedge clk);
    ack_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 sync delay", obf_n, !was_full);
    @(posedge clk);
    @(negedge clk);
    if (was_full) begin m_full = 0; m_pend = 1; end
    check_all(was_full ? "R5 ack release" : "R8 ack ignored", 1'b0);
    ack_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R6 ack high", 1'b1);
    if (!was_full) chk("R8 intr unchanged", intr, intr_before);
  endtask

  task automatic set_ie(input bit v);
    @(negedge clk);
    ie = v;
    m_ie = v;
    #1;
    check_all("R7 ie", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 obf_n", obf_n, 1'b1);
    chk("R1 intr", intr, 1'b0);
    chk("R1 dout", dout, '0);
    chk("R1 wr_ready", wr_ready, 1'b1);
    // directed corners
    do_ack();              // R8 ack while empty, no pending request
    set_ie(1);
    do_write(8'hA5);       // R2
    do_write(8'h3C);       // R3 refused
    do_ack();              // R5, R6
    set_ie(0);             // R7 masked
    set_ie(1);             // R7 revealed
    do_ack();              // R8 ack while empty with pending request
    do_write(8'hFF);       // R6 cleared by write
    do_ack();
    // constrained random
    for (int i = 0; i < 400; i++) begin
      int unsigned sel = $urandom_range(0, 9);
      if (sel < 4)      do_write(DW'($urandom));
      else if (sel < 8) do_ack();
      else              set_ie(bit'($urandom_range(0, 1)));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule